// File: doc/BRIEF.md
# Secure Low-Power Real-Time Clock Register Block

This block keeps wall-clock time in a slow, free-running low-power clock domain and presents it to software through a 32-bit register bus clocked by a fast, unrelated bus clock. It contains a sub-second counter with a parameterized width and a 32-bit seconds counter. The seconds counter advances each time the sub-second counter wraps. A 32-bit alarm compare value drives a sticky match flag, and that flag drives an interrupt output and a wakeup output, each gated by its own enable bit.

Time does not run until software has moved the block through a three-step security sequence. After reset the block is in the init state. A key word loaded into the glitch-detector register, followed by an exit request in the control register, moves it to the non-valid state. A second control write with four specific bits all set moves it to the valid state, and the counters start. Until the valid state is reached, the time and alarm registers refuse writes.

Every bus write is handed to the slow domain by a toggle handshake that holds the command steady. A busy output stays high until the slow domain has acknowledged the write. The slow domain publishes a view of all of its registers on every slow-clock edge. The bus side copies that view as a whole once a toggle has crossed, so a read never returns a partly updated value.

Top module: `lprtc_regs`

## Requirements
- R1: After reset the registers read as follows: seconds 0, sub-second 0, alarm 0xFFFFFFFF, control 0, status 0, glitch 0. The outputs alarmIrq, alarmWake and busBusy are low.
- R2: A write to control (offset 0x10) with bit 15 set moves the block from init to non-valid only when the glitch register (offset 0x18) already holds 0x41736166. Status bit 15 (offset 0x14) then reads 1. Without the key, status stays 0.
- R3: In the non-valid state, only a control write with bits 15, 14, 11 and 3 all set enters the valid state, and status bit 14 then reads 1. A control write that lacks any one of those bits leaves status at 0x8000.
- R4: Outside the valid state, writes to seconds (0x00) and alarm (0x08) are ignored. Seconds and sub-second (0x04) read 0, and alarm keeps its value.
- R5: In the valid state the sub-second counter advances by one on every slow-clock cycle and wraps at 2^SUB_W. Reads spaced n slow cycles apart differ by n modulo 2^SUB_W.
- R6: The seconds register is a full 32-bit value that can be written in the valid state. It increments when the sub-second counter wraps, and 0xFFFFFFFF rolls over to 0.
- R7: Status bit 3 sets when seconds equals the alarm value, and it stays set after the match passes. Writing 1 to status bit 3 clears it. Writing 0 to that bit leaves it unchanged.
- R8: alarmIrq is high exactly when status bit 3 and control bit 7 are both set. alarmWake is high exactly when status bit 3 and control bit 4 are both set.
- R9: busBusy rises on the bus cycle after an accepted write and stays high until the slow domain acknowledges it. A write issued while busBusy is high is dropped. The accepted write lands on the third slow-clock edge after it is issued.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| busClk | input | 1 | Fast register-bus clock |
| slowClk | input | 1 | Slow low-power timekeeping clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| busWr | input | 1 | Write strobe, one bus cycle |
| busRd | input | 1 | Read strobe, one bus cycle |
| busAddr | input | 5 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busRvalid |
| busRvalid | output | 1 | Read data valid, one cycle after busRd |
| busBusy | output | 1 | Earlier write not yet acknowledged; new writes are dropped |
| alarmIrq | output | 1 | Alarm interrupt request (slow domain) |
| alarmWake | output | 1 | Alarm wakeup request (slow domain) |

## Verification
The assertions assume three things about the inputs. The slow clock runs at least four times slower than the bus clock, so the published view stays stable while the bus side copies it. Reset reaches both domains together. Write strobes last a single bus cycle. The bench generates both clocks with a fixed 8:1 ratio and a fixed phase, and drives every strobe for exactly one cycle on the falling bus edge. It waits for busBusy to fall, plus two slow periods, before it reads back the effect of a write. The one exception is the deliberate write issued while busBusy is high. Because the phase is fixed, reads taken a known number of slow periods apart have exactly known differences.

// File: rtl/lprtc_pkg.sv
`timescale 1ns/1ps
package lprtc_pkg;
  localparam int unsigned REG_W = 32;
  localparam int unsigned ADDR_W = 5;

  // register offsets
  localparam logic [ADDR_W-1:0] OFS_SECS   = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_SUB    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_GLITCH = 5'h18;

  // control bit positions
  localparam int unsigned CB_LPEN     = 3;
  localparam int unsigned CB_WAKEEN   = 4;
  localparam int unsigned CB_IRQEN    = 7;
  localparam int unsigned CB_NSACC    = 11;
  localparam int unsigned CB_NVEXIT   = 14;
  localparam int unsigned CB_INITEXIT = 15;

  // status bit positions
  localparam int unsigned SB_MATCH    = 3;
  localparam int unsigned SB_NVDONE   = 14;
  localparam int unsigned SB_INITDONE = 15;

  typedef enum logic [1:0] {
    SEC_INIT     = 2'd0,
    SEC_NONVALID = 2'd1,
    SEC_VALID    = 2'd2
  } secState_t;

  // write command held stable across the domain crossing
  typedef struct packed {
    logic             setSecs;
    logic             setAlarm;
    logic             setCtrl;
    logic             clrStat;
    logic             setGlitch;
    logic [REG_W-1:0] data;
  } wrCmd_t;

  // coherent view of slow-domain registers
  typedef struct packed {
    logic [REG_W-1:0] secs;
    logic [REG_W-1:0] sub;
    logic [REG_W-1:0] alarm;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] stat;
    logic [REG_W-1:0] glitch;
  } regView_t;
endpackage

// File: rtl/lprtc_sync.sv
`timescale 1ns/1ps
module lprtc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lprtc_busctl.sv
`timescale 1ns/1ps
module lprtc_busctl
  import lprtc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              busClk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              busRvalid,
  output logic              busBusy,
  output wrCmd_t            cmd,
  output logic              reqTgl,
  input  logic              ackTgl,
  input  logic              pubTgl,
  input  regView_t          view
);
  logic     ackSyncd;
  logic     pubSyncd;
  logic     pubSeen;
  wrCmd_t   decoded;
  logic     writable;
  regView_t snap;

  lprtc_sync #(.STAGES(SYNC_STAGES)) u_ackSync (
    .clk(busClk), .rstN(rstN), .din(ackTgl), .dout(ackSyncd));
  lprtc_sync #(.STAGES(SYNC_STAGES)) u_pubSync (
    .clk(busClk), .rstN(rstN), .din(pubTgl), .dout(pubSyncd));

  assign busBusy = reqTgl ^ ackSyncd;

  always_comb begin
    decoded      = '0;
    decoded.data = busWdata;
    case (busAddr)
      OFS_SECS:   decoded.setSecs   = 1'b1;
      OFS_ALARM:  decoded.setAlarm  = 1'b1;
      OFS_CTRL:   decoded.setCtrl   = 1'b1;
      OFS_STAT:   decoded.clrStat   = 1'b1;
      OFS_GLITCH: decoded.setGlitch = 1'b1;
      default:    ;
    endcase
  end

  assign writable = decoded.setSecs | decoded.setAlarm | decoded.setCtrl |
                    decoded.clrStat | decoded.setGlitch;

  // launch: command held until acknowledged
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      cmd    <= '0;
      reqTgl <= 1'b0;
    end else if (busWr && !busBusy && writable) begin
      cmd    <= decoded;
      reqTgl <= ~reqTgl;
    end
  end

  // snapshot the whole view once a publish toggle has crossed
  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      snap    <= '0;
      pubSeen <= 1'b0;
    end else if (pubSyncd != pubSeen) begin
      snap    <= view;
      pubSeen <= pubSyncd;
    end
  end

  always_ff @(posedge busClk or negedge rstN) begin
    if (!rstN) begin
      busRdata  <= '0;
      busRvalid <= 1'b0;
    end else begin
      busRvalid <= busRd;
      if (busRd) begin
        case (busAddr)
          OFS_SECS:   busRdata <= snap.secs;
          OFS_SUB:    busRdata <= snap.sub;
          OFS_ALARM:  busRdata <= snap.alarm;
          OFS_CTRL:   busRdata <= snap.ctrl;
          OFS_STAT:   busRdata <= snap.stat;
          OFS_GLITCH: busRdata <= snap.glitch;
          default:    busRdata <= '0;
        endcase
      end
    end
  end

  // R9: the in-flight command does not move while busy
  p_cmd_hold_r9: assert property (@(posedge busClk) disable iff (!rstN)
    busBusy |=> ($stable(cmd) && $stable(reqTgl)));

  // R9: an accepted write raises busy on the next cycle
  p_busy_set_r9: assert property (@(posedge busClk) disable iff (!rstN)
    (busWr && !busBusy && writable) |=> busBusy);
endmodule

// File: rtl/lprtc_core.sv
`timescale 1ns/1ps
module lprtc_core
  import lprtc_pkg::*;
#(
  parameter int unsigned      SUB_W       = 15,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] GLITCH_KEY  = 32'h4173_6166
) (
  input  logic     slowClk,
  input  logic     rstN,
  input  wrCmd_t   cmd,
  input  logic     reqTgl,
  output logic     ackTgl,
  output logic     pubTgl,
  output regView_t view,
  output logic     alarmIrq,
  output logic     alarmWake
);
  localparam logic [REG_W-1:0] EXIT_MASK =
    (REG_W'(1) << CB_INITEXIT) | (REG_W'(1) << CB_NVEXIT) |
    (REG_W'(1) << CB_NSACC)    | (REG_W'(1) << CB_LPEN);

  logic             reqSyncd;
  logic             reqSeen;
  logic             apply;
  secState_t        state;
  logic [SUB_W-1:0] sub;
  logic [REG_W-1:0] secs;
  logic [REG_W-1:0] alarm;
  logic [REG_W-1:0] ctrl;
  logic [REG_W-1:0] glitch;
  logic             matchFlag;
  logic             running;
  logic             match;
  logic             flagClr;

  lprtc_sync #(.STAGES(SYNC_STAGES)) u_reqSync (
    .clk(slowClk), .rstN(rstN), .din(reqTgl), .dout(reqSyncd));

  assign apply   = reqSyncd != reqSeen;
  assign ackTgl  = reqSeen;
  assign running = state == SEC_VALID;
  assign match   = running && (secs == alarm);
  assign flagClr = apply && cmd.clrStat && cmd.data[SB_MATCH];

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      pubTgl  <= 1'b0;
    end else begin
      reqSeen <= reqSyncd;
      pubTgl  <= ~pubTgl;
    end
  end

  // security sequence
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      state <= SEC_INIT;
    end else begin
      case (state)
        SEC_INIT:
          if (apply && cmd.setCtrl && cmd.data[CB_INITEXIT] && glitch == GLITCH_KEY)
            state <= SEC_NONVALID;
        SEC_NONVALID:
          if (apply && cmd.setCtrl && ((cmd.data & EXIT_MASK) == EXIT_MASK))
            state <= SEC_VALID;
        default: ;
      endcase
    end
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      ctrl   <= '0;
      glitch <= '0;
    end else begin
      if (apply && cmd.setCtrl)   ctrl   <= cmd.data;
      if (apply && cmd.setGlitch) glitch <= cmd.data;
    end
  end

  // timekeeping
  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) begin
      sub   <= '0;
      secs  <= '0;
      alarm <= '1;
    end else if (running) begin
      sub <= sub + SUB_W'(1);
      if (apply && cmd.setSecs) secs <= cmd.data;
      else if (&sub)            secs <= secs + REG_W'(1);
      if (apply && cmd.setAlarm) alarm <= cmd.data;
    end
  end

  always_ff @(posedge slowClk or negedge rstN) begin
    if (!rstN) matchFlag <= 1'b0;
    else       matchFlag <= (matchFlag && !flagClr) || match;
  end

  assign alarmIrq  = matchFlag && ctrl[CB_IRQEN];
  assign alarmWake = matchFlag && ctrl[CB_WAKEEN];

  always_comb begin
    view                     = '0;
    view.secs                = secs;
    view.sub                 = REG_W'(sub);
    view.alarm               = alarm;
    view.ctrl                = ctrl;
    view.glitch              = glitch;
    view.stat[SB_MATCH]      = matchFlag;
    view.stat[SB_NVDONE]     = state == SEC_VALID;
    view.stat[SB_INITDONE]   = state != SEC_INIT;
  end

  // R4: time is held at zero until the valid state
  p_hold_time_r4: assert property (@(posedge slowClk) disable iff (!rstN)
    (state != SEC_VALID) |-> (secs == '0 && sub == '0));

  // R5: sub-second steps by one per cycle once running
  p_sub_step_r5: assert property (@(posedge slowClk) disable iff (!rstN)
    (state == SEC_VALID && $past(state) == SEC_VALID) |-> (sub == SUB_W'($past(sub) + SUB_W'(1))));

  // R7: the flag only rises after a compare hit
  p_flag_cause_r7: assert property (@(posedge slowClk) disable iff (!rstN)
    $rose(matchFlag) |-> ($past(secs) == $past(alarm)));

  // R2: leaving init needs the key already stored
  p_init_key_r2: assert property (@(posedge slowClk) disable iff (!rstN)
    (state == SEC_NONVALID && $past(state) == SEC_INIT) |-> ($past(glitch) == GLITCH_KEY));

  // R3: the valid state is reached only from non-valid
  p_valid_order_r3: assert property (@(posedge slowClk) disable iff (!rstN)
    (state == SEC_VALID && $past(state) != SEC_VALID) |-> ($past(state) == SEC_NONVALID));
endmodule

// File: rtl/lprtc_regs.sv
`timescale 1ns/1ps
module lprtc_regs
  import lprtc_pkg::*;
#(
  parameter int unsigned      SUB_W       = 15,
  parameter int unsigned      SYNC_STAGES = 2,
  parameter logic [REG_W-1:0] GLITCH_KEY  = 32'h4173_6166
) (
  input  logic              busClk,
  input  logic              slowClk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWdata,
  output logic [REG_W-1:0]  busRdata,
  output logic              busRvalid,
  output logic              busBusy,
  output logic              alarmIrq,
  output logic              alarmWake
);
  wrCmd_t   cmd;
  logic     reqTgl;
  logic     ackTgl;
  logic     pubTgl;
  regView_t view;

  lprtc_busctl #(.SYNC_STAGES(SYNC_STAGES)) u_busctl (
    .busClk(busClk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .busRvalid(busRvalid), .busBusy(busBusy), .cmd(cmd), .reqTgl(reqTgl),
    .ackTgl(ackTgl), .pubTgl(pubTgl), .view(view));

  lprtc_core #(.SUB_W(SUB_W), .SYNC_STAGES(SYNC_STAGES), .GLITCH_KEY(GLITCH_KEY)) u_core (
    .slowClk(slowClk), .rstN(rstN), .cmd(cmd), .reqTgl(reqTgl),
    .ackTgl(ackTgl), .pubTgl(pubTgl), .view(view),
    .alarmIrq(alarmIrq), .alarmWake(alarmWake));
endmodule

// File: tb/test_lprtc_regs.sv
`timescale 1ns/1ps
module test_lprtc_regs;
  localparam int SUBW  = 4;
  localparam int SUBN  = 1 << SUBW;
  localparam int RATIO = 8;

  logic        busClk = 1'b0;
  logic        slowClk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic        busRd = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        busBusy;
  logic        alarmIrq;
  logic        alarmWake;

  always #5  busClk  = ~busClk;
  always #40 slowClk = ~slowClk;

  lprtc_regs #(.SUB_W(SUBW)) i_lprtc_regs (
    .busClk(busClk), .slowClk(slowClk), .rstN(rstN), .busWr(busWr), .busRd(busRd),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .busRvalid(busRvalid),
    .busBusy(busBusy), .alarmIrq(alarmIrq), .alarmWake(alarmWake));

  typedef struct {
    logic [31:0] exp;
    logic [31:0] mask;
    string       tag;
  } rdItem_t;

  rdItem_t     sb[$];
  rdItem_t     item;
  logic [31:0] lastRd = '0;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;

  // monitor: pops expected reads as data returns
  always @(negedge busClk) begin
    if (busRvalid) begin
      item   = sb.pop_front();
      lastRd = busRdata;
      if (item.mask != 0) begin
        checks++;
        if ((busRdata & item.mask) != (item.exp & item.mask)) begin
          errors++;
          $display("FAIL %s read got %h expected %h", item.tag, busRdata, item.exp);
        end
      end
    end
  end

  task automatic rdReg(input logic [4:0] a, input logic [31:0] e, input logic [31:0] m, input string tag);
    sb.push_back('{exp: e, mask: m, tag: tag});
    busAddr = a;
    busRd   = 1'b1;
    @(negedge busClk);
    busRd = 1'b0;
    @(negedge busClk);
  endtask

  task automatic wrReg(input logic [4:0] a, input logic [31:0] d);
    while (busBusy) @(negedge busClk);
    busAddr  = a;
    busWdata = d;
    busWr    = 1'b1;
    @(negedge busClk);
    busWr = 1'b0;
    while (busBusy) @(negedge busClk);
    repeat (2 * RATIO) @(negedge busClk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] e);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, act, e);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge busClk);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    int          s0;
    logic [31:0] v;
    repeat (4 * RATIO) @(negedge busClk);
    rstN = 1'b1;
    repeat (4 * RATIO) @(negedge busClk);

    // R1 reset state
    rdReg(5'h00, 32'h0, '1, "R1 secs");
    rdReg(5'h04, 32'h0, '1, "R1 sub");
    rdReg(5'h08, 32'hFFFF_FFFF, '1, "R1 alarm");
    rdReg(5'h10, 32'h0, '1, "R1 ctrl");
    rdReg(5'h14, 32'h0, '1, "R1 status");
    rdReg(5'h18, 32'h0, '1, "R1 glitch");
    chk("R1 irq", 32'(alarmIrq), 0);
    chk("R1 wake", 32'(alarmWake), 0);
    chk("R1 busy", 32'(busBusy), 0);

    // R4 time writes ignored in init
    wrReg(5'h00, 32'd55);
    wrReg(5'h08, 32'd77);
    rdReg(5'h00, 32'h0, '1, "R4 secs in init");
    rdReg(5'h08, 32'hFFFF_FFFF, '1, "R4 alarm in init");
    rdReg(5'h04, 32'h0, '1, "R4 sub in init");

    // R2 no key: no exit
    wrReg(5'h10, 32'h0000_C808);
    rdReg(5'h14, 32'h0, '1, "R2 exit without key");

    // R9 second write while busy is dropped
    busAddr = 5'h18; busWdata = 32'h4173_6166; busWr = 1'b1;
    @(negedge busClk);
    chk("R9 busy after write", 32'(busBusy), 1);
    busWdata = 32'h0;
    @(negedge busClk);
    busWr = 1'b0;
    while (busBusy) @(negedge busClk);
    repeat (2 * RATIO) @(negedge busClk);
    rdReg(5'h18, 32'h4173_6166, '1, "R9 dropped write");

    // R2 exit with key
    wrReg(5'h10, 32'h0000_8800);
    rdReg(5'h14, 32'h0000_8000, '1, "R2 init exit");
    wrReg(5'h00, 32'd9);
    rdReg(5'h00, 32'h0, '1, "R4 secs in non-valid");

    // R3 partial then full request
    wrReg(5'h10, 32'h0000_C800);
    rdReg(5'h14, 32'h0000_8000, '1, "R3 partial request");
    wrReg(5'h10, 32'h0000_C808);
    rdReg(5'h14, 32'h0000_C000, '1, "R3 valid entry");

    // R5 sub-second spacing, 5 slow periods apart
    rdReg(5'h04, 32'h0, 32'h0, "R5 capture");
    s0 = int'(lastRd);
    repeat (5 * RATIO - 2) @(negedge busClk);
    rdReg(5'h04, 32'((s0 + 5) % SUBN), '1, "R5 step");

    // R6 write seconds, then one wrap later
    wrReg(5'h00, 32'd100);
    rdReg(5'h04, 32'h0, 32'h0, "R6 capture");
    s0 = int'(lastRd);
    repeat ((SUBN - s0 + 2) * RATIO) @(negedge busClk);
    rdReg(5'h00, 32'd101, '1, "R6 increment");

    // R7 alarm match, sticky, write-one-to-clear
    rdReg(5'h00, 32'h0, 32'h0, "R7 capture");
    v = lastRd;
    wrReg(5'h08, v + 32'd1);
    repeat (20 * RATIO) @(negedge busClk);
    rdReg(5'h14, 32'h0000_C008, '1, "R7 flag set");
    repeat (20 * RATIO) @(negedge busClk);
    rdReg(5'h14, 32'h0000_C008, '1, "R7 flag sticky");
    wrReg(5'h14, 32'h0);
    rdReg(5'h14, 32'h0000_C008, '1, "R7 zero write keeps flag");

    // R8 output gating
    chk("R8 irq disabled", 32'(alarmIrq), 0);
    chk("R8 wake disabled", 32'(alarmWake), 0);
    wrReg(5'h10, 32'h0000_0080);
    chk("R8 irq enabled", 32'(alarmIrq), 1);
    chk("R8 wake off", 32'(alarmWake), 0);
    wrReg(5'h10, 32'h0000_0010);
    chk("R8 irq off", 32'(alarmIrq), 0);
    chk("R8 wake enabled", 32'(alarmWake), 1);
    rdReg(5'h10, 32'h0000_0010, '1, "R8 ctrl readback");
    wrReg(5'h14, 32'h0000_0008);
    rdReg(5'h14, 32'h0000_C000, '1, "R7 flag cleared");
    chk("R8 wake after clear", 32'(alarmWake), 0);

    // R6 roll-over
    wrReg(5'h00, 32'hFFFF_FFFF);
    rdReg(5'h04, 32'h0, 32'h0, "R6 capture wrap");
    s0 = int'(lastRd);
    repeat ((SUBN - s0 + 2) * RATIO) @(negedge busClk);
    rdReg(5'h00, 32'h0, '1, "R6 roll-over");

    finishRun();
  end
endmodule